// File: doc/BRIEF.md
# Self-Healing Triple-Redundant Counter

This block is a wrap-around binary counter held in three identical register copies. Three bitwise two-of-three voters read all three copies, and each voter drives one output. A corrupted copy is therefore outvoted, so all three outputs keep the true count.

In the default feedback mode, every copy computes its next value from its own voter's output rather than from its own register. A copy that has been upset therefore rejoins the other two on the very next clock edge, and no reset is needed. A plain mode, chosen by a parameter, keeps each copy counting from its own register. In that mode a disturbed copy stays out of step until a synchronous reset.

Each copy has a test input that overwrites its register for one cycle. A disagreement flag is high whenever the three copies do not all hold the same value.

The block has no internal state machine. Its only sequencing is the per-copy register update. Its variant enumeration has two members:
- `MODE_FEEDBACK`: a copy loads from its voted value.
- `MODE_PLAIN`: a copy loads from its own register.

Each copy takes one of four transitions on a clock edge, in this priority order:
1. clear, when `rst` is high.
2. overwrite, when that copy's `inj_en` bit is high.
3. advance, when `en` is high.
4. hold, otherwise.

Top module: `tmr_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three copies to zero. After that edge, `q_a`, `q_b` and `q_c` read 0 and `mismatch` reads 0.
- R2: While `en` is high and no copy is being overwritten, the voted value rises by exactly one per clock edge. While `en` is low, the voted value holds.
- R3: The count wraps modulo 2^WIDTH, so the value after 2^WIDTH-1 is 0.
- R4: Each output is the bitwise majority (a&b)|(b&c)|(a&c) of the three copies. As a result, `q_a`, `q_b` and `q_c` are always equal to each other.
- R5: When a single copy is overwritten with any value, the outputs stay on the correct count in both modes.
- R6: In `MODE_FEEDBACK`, a copy that was overwritten alone agrees with the other two one clock edge later, with no reset. `mismatch` is high for exactly that one cycle.
- R7: In `MODE_PLAIN`, a copy that was overwritten alone stays divergent. `mismatch` stays high on every following cycle until `rst` is applied.
- R8: `mismatch` is high in exactly the cycles in which the three copies are not all equal.
- R9: `inj_en[i]` high at an edge loads `inj_val[i]` into copy i (bit 0 selects copy 0, and so on). This takes precedence over `en`, and `rst` takes precedence over it.
- R10: When two copies are overwritten with the same value, the outputs take that value. The two-of-three vote is defeated; this is accepted behaviour and carries no guarantee of a correct count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| inj_en | input | 3 | Per-copy overwrite strobe; bit i selects copy i |
| inj_val | input | 3 x WIDTH | Value to load into copy i, in slice i |
| q_a | output | WIDTH | Voted count from voter 0 |
| q_b | output | WIDTH | Voted count from voter 1 |
| q_c | output | WIDTH | Voted count from voter 2 |
| mismatch | output | 1 | High while the copies disagree |

## Verification
The bench runs both variants side by side on the same stimulus and compares each against a three-copy reference model.

It targets the following corner cases:
- **Single-copy upset during counting.** A design without feedback, or one that feeds back the wrong lane, leaves `mismatch` stuck high in feedback mode.
- **The same upset in plain mode.** A design that resynchronizes here anyway drops `mismatch` when it should stay high.
- **Overwrite while counting is disabled.** A feedback path that skips the hold case would fail to pull the faulty copy back.
- **Wrap from all-ones to zero.** An off-by-one in the increment shows up at this boundary.
- **Two-copy upsets.** A voter that uses OR or AND instead of the majority fails here.
- **Reset arriving together with an overwrite.** A design that gives the overwrite priority over reset fails here.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int LANES = 3;

    typedef enum logic {
        MODE_PLAIN    = 1'b0,
        MODE_FEEDBACK = 1'b1
    } tmr_mode_e;

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    input  logic [WIDTH-1:0] in_z,
    output logic [WIDTH-1:0] vote
);

    // Bitwise two-of-three majority
    always_comb begin
        vote = (in_x & in_y) | (in_y & in_z) | (in_x & in_z);
    end

endmodule

// File: rtl/tmr_replica.sv
module tmr_replica
    import tmr_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter tmr_mode_e MODE  = MODE_FEEDBACK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] voted,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] nxt;

    // Variant choice: where the next value is built from
    generate
        if (MODE == MODE_FEEDBACK) begin : g_fb
            assign base = voted;
        end else begin : g_plain
            assign base = state;
        end
    endgenerate

    always_comb begin
        if (load) begin
            nxt = load_val;
        end else if (en) begin
            nxt = base + {{(WIDTH-1){1'b0}}, 1'b1};
        end else begin
            nxt = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter tmr_mode_e MODE  = MODE_FEEDBACK
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [LANES-1:0]            inj_en,
    input  logic [LANES-1:0][WIDTH-1:0] inj_val,
    output logic [WIDTH-1:0]            q_a,
    output logic [WIDTH-1:0]            q_b,
    output logic [WIDTH-1:0]            q_c,
    output logic                        mismatch
);

    logic [WIDTH-1:0] copy_q [LANES];
    logic [WIDTH-1:0] vote_q [LANES];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            tmr_replica #(
                .WIDTH (WIDTH),
                .MODE  (MODE)
            ) u_rep (
                .clk      (clk),
                .rst      (rst),
                .en       (en),
                .load     (inj_en[i]),
                .load_val (inj_val[i]),
                .voted    (vote_q[i]),
                .state    (copy_q[i])
            );

            tmr_voter #(
                .WIDTH (WIDTH)
            ) u_vote (
                .in_x (copy_q[0]),
                .in_y (copy_q[1]),
                .in_z (copy_q[2]),
                .vote (vote_q[i])
            );
        end
    endgenerate

    assign q_a = vote_q[0];
    assign q_b = vote_q[1];
    assign q_c = vote_q[2];

    always_comb begin
        mismatch = !((copy_q[0] == copy_q[1]) && (copy_q[1] == copy_q[2]));
    end

    // ---------------- assertions ----------------
    logic was_rst;
    logic armed;

    always_ff @(posedge clk) begin
        was_rst <= rst;
        armed   <= !rst;
        if (was_rst) begin
            assert_reset_clear_R1: assert (q_a == '0 && q_b == '0 && q_c == '0 && !mismatch);
        end
    end

    assert_outputs_agree_R4: assert property (@(posedge clk) disable iff (rst)
        (q_a == q_b) && (q_b == q_c));

    assert_vote_follows_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (copy_q[0] == copy_q[2]) |-> (q_a == copy_q[0]));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_FEEDBACK && armed && $past(en) && $past(inj_en) == '0)
            |-> (q_a == $past(q_a) + {{(WIDTH-1){1'b0}}, 1'b1}));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_FEEDBACK && armed && !$past(en) && $past(inj_en) == '0)
            |-> (q_a == $past(q_a)));

    assert_resync_R6: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_FEEDBACK && mismatch && inj_en == '0) |=> !mismatch);

    assert_stays_apart_R7: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_PLAIN && mismatch && inj_en == '0) |=> mismatch);

    assert_inject_load_R9: assert property (@(posedge clk) disable iff (rst)
        inj_en[1] |=> (copy_q[1] == $past(inj_val[1])));

endmodule

// File: tb/sim_tmr_counter.sv
`timescale 1ns/1ps
module sim_tmr_counter;
    import tmr_pkg::*;

    localparam int W = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic [LANES-1:0]        inj_en = '0;
    logic [LANES-1:0][W-1:0] inj_val = '0;

    logic [W-1:0] fa, fb, fc, pa, pb, pc;
    logic         fmis, pmis;

    always #2.5 clk = ~clk;

    tmr_counter #(.WIDTH(W), .MODE(MODE_FEEDBACK)) u0 (
        .clk(clk), .rst(rst), .en(en), .inj_en(inj_en), .inj_val(inj_val),
        .q_a(fa), .q_b(fb), .q_c(fc), .mismatch(fmis));

    tmr_counter #(.WIDTH(W), .MODE(MODE_PLAIN)) u1 (
        .clk(clk), .rst(rst), .en(en), .inj_en(inj_en), .inj_val(inj_val),
        .q_a(pa), .q_b(pb), .q_c(pc), .mismatch(pmis));

    typedef struct {
        logic [W-1:0] f_q;
        logic         f_mis;
        logic [W-1:0] p_q;
        logic         p_mis;
        string        tag;
    } exp_t;

    exp_t expq [$];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [W-1:0] mf [LANES];
    logic [W-1:0] mp [LANES];

    function automatic logic [W-1:0] maj(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    task automatic step(input logic r, input logic e, input logic [2:0] ie,
                        input logic [W-1:0] v0, input logic [W-1:0] v1,
                        input logic [W-1:0] v2, input string tag);
        logic [W-1:0] vf;
        logic [W-1:0] vals [LANES];
        exp_t it;
        @(negedge clk);
        #1;
        rst = r; en = e; inj_en = ie;
        inj_val[0] = v0; inj_val[1] = v1; inj_val[2] = v2;
        vals[0] = v0; vals[1] = v1; vals[2] = v2;
        vf = maj(mf[0], mf[1], mf[2]);
        for (int i = 0; i < LANES; i++) begin
            if (r) begin
                mf[i] = '0; mp[i] = '0;
            end else if (ie[i]) begin
                mf[i] = vals[i]; mp[i] = vals[i];
            end else if (e) begin
                mf[i] = vf + 1'b1; mp[i] = mp[i] + 1'b1;
            end else begin
                mf[i] = vf;
            end
        end
        it.f_q   = maj(mf[0], mf[1], mf[2]);
        it.f_mis = !(mf[0] == mf[1] && mf[1] == mf[2]);
        it.p_q   = maj(mp[0], mp[1], mp[2]);
        it.p_mis = !(mp[0] == mp[1] && mp[1] == mp[2]);
        it.tag   = tag;
        expq.push_back(it);
    endtask

    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t it;
            it = expq.pop_front();
            checks++;
            if (fa !== it.f_q || fb !== it.f_q || fc !== it.f_q || fmis !== it.f_mis) begin
                errors++;
                $display("FAIL %s feedback: got %0h/%0h/%0h mis=%0b expected %0h mis=%0b",
                         it.tag, fa, fb, fc, fmis, it.f_q, it.f_mis);
            end
            checks++;
            if (pa !== it.p_q || pb !== it.p_q || pc !== it.p_q || pmis !== it.p_mis) begin
                errors++;
                $display("FAIL %s plain: got %0h/%0h/%0h mis=%0b expected %0h mis=%0b",
                         it.tag, pa, pb, pc, pmis, it.p_q, it.p_mis);
            end
        end
    end

    initial begin
        for (int i = 0; i < LANES; i++) begin
            mf[i] = '0; mp[i] = '0;
        end
        step(1, 0, 3'b000, 0, 0, 0, "R1 reset");
        step(1, 0, 3'b000, 0, 0, 0, "R1 reset");
        for (int k = 0; k < 5; k++) step(0, 1, 3'b000, 0, 0, 0, "R2 count");
        for (int k = 0; k < 3; k++) step(0, 0, 3'b000, 0, 0, 0, "R2 hold");
        step(0, 1, 3'b010, 0, 8'hAA, 0, "R5 R8 R9 single upset");
        for (int k = 0; k < 4; k++) step(0, 1, 3'b000, 0, 0, 0, "R6 R7 after upset");
        step(0, 0, 3'b100, 0, 0, 8'h13, "R9 upset while disabled");
        step(0, 0, 3'b000, 0, 0, 0, "R6 R7 resync on hold");
        step(1, 0, 3'b000, 0, 0, 0, "R1 R7 reset clears");
        step(0, 0, 3'b111, 8'hFD, 8'hFD, 8'hFD, "R9 preload");
        for (int k = 0; k < 5; k++) step(0, 1, 3'b000, 0, 0, 0, "R3 wrap");
        step(0, 1, 3'b101, 8'h40, 0, 8'h40, "R10 double upset");
        step(0, 1, 3'b000, 0, 0, 0, "R10 R6 after double");
        step(0, 1, 3'b001, 8'h0F, 0, 0, "R4 R5 upset copy0");
        step(0, 1, 3'b000, 0, 0, 0, "R4 R6 after copy0");
        step(1, 1, 3'b111, 8'h55, 8'h55, 8'h55, "R1 R9 reset beats overwrite");
        step(0, 1, 3'b000, 0, 0, 0, "R2 count from zero");
        step(0, 0, 3'b000, 0, 0, 0, "R2 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule